// File: doc/BRIEF.md
# Cascadable Synchronous Offset Counter

This block is a chain of identical 4-bit synchronous up-counter stages. Each stage has a synchronous clear, a parallel load, and two count enables. The enable `en_p` only lets a stage advance. The enable `en_t` lets it advance and also qualifies its carry. Each stage passes its carry to the `en_t` of the stage above it. The upper stage therefore steps only in the cycle where the lower stage wraps from all ones. Every change of state happens on the rising clock edge. The block has no asynchronous path into the state.

A wrapper around the chain adds two offset modes, built only from the synchronous load and clear:

- **Start mode:** the chain carry triggers a reload of a parameterised start value. The count therefore restarts there instead of at zero.
- **End mode:** a decoded terminal value triggers a synchronous clear. The count therefore runs from zero up to that value and then wraps.

The external clear and load keep working in both modes. A 2-bit mode input selects the behaviour at run time.

Top module: `offset_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the state `q` becomes all zeros on that edge.
- R2: With `clr_n` and `ld_n` high, `q` increments by one on a rising edge when `en_p` and `en_t` are both high. Otherwise it holds its value.
- R3: `carry` is combinational. It is high exactly when `q` is all ones and `en_t` is high, independent of `en_p`.
- R4: With `clr_n` high, `ld_n` low copies `ld_data` into `q` on the next rising edge, whatever the enables.
- R5: `clr_n` low forces `q` to zero on the next rising edge, even if `ld_n` is also low.
- R6: An external load takes precedence over counting when both are requested in one cycle.
- R7: The stages form a cascade. Bits `q[7:4]` change through counting only in a cycle where `q[3:0]` is 1111 and both enables are high. The full 8-bit count goes from 0x0F to 0x10, and from 0xFF to 0x00 in the free mode.
- R8: In start mode, with both enables high and `q` all ones, the next edge loads the start value (default 0x06) instead of wrapping to zero.
- R9: In end mode, with both enables high and `q` equal to the terminal value (default 0x0D), the next edge clears `q` to zero.
- R10: In the offset modes, the external clear and load still take effect. An external load in the terminal state wins over the automatic clear and loads `ld_data`.
- R11: The mode encoding is 2'b00 free, 2'b01 start, 2'b10 end. The code 2'b11 behaves as free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to zero |
| mode | input | 2 | 00 free, 01 start-offset, 10 end-offset, 11 free |
| clr_n | input | 1 | Synchronous clear, active low |
| ld_n | input | 1 | Synchronous parallel load, active low |
| en_p | input | 1 | Count enable (advance only) |
| en_t | input | 1 | Count enable that also qualifies the carry |
| ld_data | input | 8 | Parallel load value |
| q | output | 8 | Counter state, stage 0 in bits 3:0 |
| carry | output | 1 | Chain carry: state all ones and `en_t` high |

## Verification
The collision of interest is the automatic offset action against an external request in the same cycle. In start mode, the reload at all ones can meet an external load or clear. In end mode, the terminal clear can meet an external load. Directed cycles bring the chain to 0xFF or 0x0D with both enables high and then assert `ld_n` and/or `clr_n` together with the automatic trigger. The random stream also biases `ld_data` towards those boundary values so that such collisions recur. Each outcome is judged against a bench model that applies the order clear, then external load, then automatic action, then counting.

// File: rtl/ocnt_pkg.sv
package ocnt_pkg;

    localparam int CNT_W = 4;

    typedef logic [CNT_W-1:0] nib_t;

    typedef enum logic [1:0] {
        MODE_FREE     = 2'b00,
        MODE_START    = 2'b01,
        MODE_END      = 2'b10,
        MODE_FREE_ALT = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'b00,
        ACT_COUNT = 2'b01,
        ACT_LOAD  = 2'b10,
        ACT_CLEAR = 2'b11
    } act_e;

    // Per-stage control requested by the offset logic (active high inside).
    typedef struct packed {
        logic clr;
        logic ld;
    } stage_ctl_t;

    // Priority: clear, then load, then count, else hold.
    function automatic act_e pick_act(logic clr, logic ld, logic adv);
        if (clr)      return ACT_CLEAR;
        else if (ld)  return ACT_LOAD;
        else if (adv) return ACT_COUNT;
        else          return ACT_HOLD;
    endfunction

    function automatic nib_t nib_next(act_e a, nib_t cur, nib_t din);
        case (a)
            ACT_CLEAR: return '0;
            ACT_LOAD:  return din;
            ACT_COUNT: return cur + nib_t'(1);
            default:   return cur;
        endcase
    endfunction

endpackage

// File: rtl/ocnt_stage.sv
module ocnt_stage
    import ocnt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  stage_ctl_t ctl,
    input  logic       en_p,
    input  logic       en_t,
    input  nib_t       din,
    output nib_t       q,
    output logic       carry
);

    act_e act;

    always_comb begin
        act = pick_act(ctl.clr, ctl.ld, en_p & en_t);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= nib_next(act, q, din);
        end
    end

    assign carry = (&q) & en_t;

endmodule

// File: rtl/ocnt_chain.sv
module ocnt_chain
    import ocnt_pkg::*;
#(
    parameter int STAGES = 2,
    localparam int TW = STAGES * CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  stage_ctl_t    ctl,
    input  logic          en_p,
    input  logic          en_t,
    input  logic [TW-1:0] din,
    output logic [TW-1:0] q,
    output logic          carry
);

    // t_link[i] is the T enable of stage i; t_link[STAGES] is the chain carry.
    logic [STAGES:0] t_link;

    assign t_link[0] = en_t;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        nib_t q_s;
        logic c_s;

        ocnt_stage u_stage (
            .clk   (clk),
            .rst   (rst),
            .ctl   (ctl),
            .en_p  (en_p),
            .en_t  (t_link[g]),
            .din   (din[g*CNT_W +: CNT_W]),
            .q     (q_s),
            .carry (c_s)
        );

        assign q[g*CNT_W +: CNT_W] = q_s;
        assign t_link[g+1]         = c_s;
    end

    assign carry = t_link[STAGES];

endmodule

// File: rtl/ocnt_offset.sv
module ocnt_offset
    import ocnt_pkg::*;
#(
    parameter int TW = 8,
    parameter logic [TW-1:0] START_VAL = TW'(6),
    parameter logic [TW-1:0] TERM_VAL  = TW'(13)
) (
    input  logic [1:0]    mode,
    input  logic [TW-1:0] q,
    input  logic          carry,
    input  logic          clr_n,
    input  logic          ld_n,
    input  logic          en_p,
    input  logic          en_t,
    input  logic [TW-1:0] ld_data,
    output stage_ctl_t    ctl,
    output logic [TW-1:0] ld_val
);

    mode_e md;
    logic  auto_reload;
    logic  auto_clear;

    always_comb begin
        md          = mode_e'(mode);
        auto_reload = (md == MODE_START) && carry && en_p;
        auto_clear  = (md == MODE_END) && en_p && en_t
                      && (q == TERM_VAL) && ld_n;
        ctl.clr     = !clr_n || auto_clear;
        ctl.ld      = !ld_n || auto_reload;
        ld_val      = !ld_n ? ld_data : START_VAL;
    end

endmodule

// File: rtl/offset_counter.sv
module offset_counter
    import ocnt_pkg::*;
#(
    parameter int STAGES = 2,
    localparam int TW = STAGES * CNT_W,
    parameter logic [TW-1:0] START_VAL = TW'(6),
    parameter logic [TW-1:0] TERM_VAL  = TW'(13)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode,
    input  logic          clr_n,
    input  logic          ld_n,
    input  logic          en_p,
    input  logic          en_t,
    input  logic [TW-1:0] ld_data,
    output logic [TW-1:0] q,
    output logic          carry
);

    stage_ctl_t    ctl;
    logic [TW-1:0] ld_val;

    ocnt_offset #(
        .TW        (TW),
        .START_VAL (START_VAL),
        .TERM_VAL  (TERM_VAL)
    ) u_offset (
        .mode    (mode),
        .q       (q),
        .carry   (carry),
        .clr_n   (clr_n),
        .ld_n    (ld_n),
        .en_p    (en_p),
        .en_t    (en_t),
        .ld_data (ld_data),
        .ctl     (ctl),
        .ld_val  (ld_val)
    );

    ocnt_chain #(
        .STAGES (STAGES)
    ) u_chain (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .en_p  (en_p),
        .en_t  (en_t),
        .din   (ld_val),
        .q     (q),
        .carry (carry)
    );

endmodule

// File: rtl/offset_counter_chk.sv
module offset_counter_chk
    import ocnt_pkg::*;
#(
    parameter int STAGES = 2,
    localparam int TW = STAGES * CNT_W,
    parameter logic [TW-1:0] START_VAL = TW'(6),
    parameter logic [TW-1:0] TERM_VAL  = TW'(13)
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    mode,
    input logic          clr_n,
    input logic          ld_n,
    input logic          en_p,
    input logic          en_t,
    input logic [TW-1:0] ld_data,
    input logic [TW-1:0] q,
    input logic          carry
);

    // R1
    reset_zero_chk: assert property (@(posedge clk) rst |=> (q == '0));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_n && ld_n && !(en_p && en_t) && !(mode == 2'b10 && q == TERM_VAL))
        |=> $stable(q));

    // R3
    carry_t_chk: assert property (@(posedge clk) disable iff (rst)
        !en_t |-> !carry);

    // R3
    carry_ones_chk: assert property (@(posedge clk) disable iff (rst)
        carry |-> (q == '1));

    // R5
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> (q == '0));

    // R4
    load_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !ld_n) |=> (q == $past(ld_data)));

    // R7
    upper_still_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_n && ld_n && mode == 2'b00 && q[CNT_W-1:0] != '1)
        |=> (q[TW-1:CNT_W] == $past(q[TW-1:CNT_W])));

    // R8
    start_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && clr_n && ld_n && en_p && en_t && q == '1)
        |=> (q == START_VAL));

    // R9
    end_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b10 && clr_n && ld_n && en_p && en_t && q == TERM_VAL)
        |=> (q == '0));

endmodule

bind offset_counter offset_counter_chk #(
    .STAGES    (STAGES),
    .START_VAL (START_VAL),
    .TERM_VAL  (TERM_VAL)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .clr_n   (clr_n),
    .ld_n    (ld_n),
    .en_p    (en_p),
    .en_t    (en_t),
    .ld_data (ld_data),
    .q       (q),
    .carry   (carry)
);

// File: tb/test_offset_counter.sv
`timescale 1ns/1ps
module test_offset_counter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       clr_n = 1'b1;
    logic       ld_n = 1'b1;
    logic       en_p = 1'b0;
    logic       en_t = 1'b0;
    logic [7:0] ld_data = 8'h00;
    logic [7:0] q;
    logic       carry;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    logic [7:0] q_exp = 8'h00;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    offset_counter i_offset_counter (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .clr_n   (clr_n),
        .ld_n    (ld_n),
        .en_p    (en_p),
        .en_t    (en_t),
        .ld_data (ld_data),
        .q       (q),
        .carry   (carry)
    );

    function automatic logic [7:0] model(logic [7:0] cur, logic [1:0] m,
                                         logic c, logic l, logic p, logic t,
                                         logic [7:0] d);
        if (!c) return 8'h00;
        if (!l) return d;
        if (!(p && t)) return cur;
        if (m == 2'b01 && cur == 8'hFF) return 8'h06;
        if (m == 2'b10 && cur == 8'h0D) return 8'h00;
        return cur + 8'h01;
    endfunction

    function automatic string pick_tag(logic [7:0] cur, logic [1:0] m,
                                       logic c, logic l, logic p, logic t);
        if (!c) return "R5";
        if (!l) return "R4";
        if (!(p && t)) return "R2";
        if (m == 2'b01 && cur == 8'hFF) return "R8";
        if (m == 2'b10 && cur == 8'h0D) return "R9";
        if (cur[3:0] == 4'hF) return "R7";
        return "R2";
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs after a falling edge, check carry, then q.
    task automatic step(logic [1:0] m, logic c, logic l, logic p, logic t,
                        logic [7:0] d, string tag);
        logic [7:0] nxt;
        string      tg;
        mode = m; clr_n = c; ld_n = l; en_p = p; en_t = t; ld_data = d;
        #1;
        chk("R3", {7'b0, carry}, {7'b0, (q_exp == 8'hFF) && t});
        nxt = model(q_exp, m, c, l, p, t, d);
        tg  = (tag == "") ? pick_tag(q_exp, m, c, l, p, t) : tag;
        @(posedge clk);
        @(negedge clk);
        q_exp = nxt;
        chk(tg, q, q_exp);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        q_exp = 8'h00;
        chk("R1", q, 8'h00);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h5EED_0C7A);
        @(negedge clk);
        @(negedge clk);
        do_reset();

        // Free counting and hold (R2), carry (R3)
        step(2'b00, 1, 1, 1, 1, 8'h00, "R2");
        step(2'b00, 1, 1, 0, 1, 8'h00, "R2");
        step(2'b00, 1, 1, 1, 0, 8'h00, "R2");
        // Load with enables off (R4)
        step(2'b00, 1, 0, 0, 0, 8'h0F, "R4");
        // Cascade 0x0F -> 0x10 (R7)
        step(2'b00, 1, 1, 1, 1, 8'h00, "R7");
        // Load 0xFF then carry while only T high, P low: hold (R3, R2)
        step(2'b00, 1, 0, 1, 1, 8'hFF, "R6");
        step(2'b00, 1, 1, 0, 1, 8'h00, "R3");
        // Free wrap 0xFF -> 0x00 (R7)
        step(2'b00, 1, 0, 0, 0, 8'hFF, "R4");
        step(2'b00, 1, 1, 1, 1, 8'h00, "R7");
        // Clear beats load (R5)
        step(2'b00, 1, 0, 0, 0, 8'h33, "R4");
        step(2'b00, 0, 0, 1, 1, 8'h77, "R5");
        // Start mode reload (R8)
        step(2'b01, 1, 0, 0, 0, 8'hFE, "R4");
        step(2'b01, 1, 1, 1, 1, 8'h00, "R8");
        step(2'b01, 1, 1, 1, 1, 8'h00, "R8");
        // Start mode: external load at all ones wins over reload (R10)
        step(2'b01, 1, 0, 0, 0, 8'hFF, "R4");
        step(2'b01, 1, 0, 1, 1, 8'hA5, "R10");
        // Start mode: external clear at all ones (R10)
        step(2'b01, 1, 0, 0, 0, 8'hFF, "R4");
        step(2'b01, 0, 1, 1, 1, 8'h00, "R10");
        // End mode clear (R9)
        step(2'b10, 1, 0, 0, 0, 8'h0C, "R4");
        step(2'b10, 1, 1, 1, 1, 8'h00, "R9");
        step(2'b10, 1, 1, 1, 1, 8'h00, "R9");
        // End mode terminal held when enables low (R9)
        step(2'b10, 1, 0, 0, 0, 8'h0D, "R4");
        step(2'b10, 1, 1, 0, 1, 8'h00, "R9");
        // End mode external load at terminal wins (R10)
        step(2'b10, 1, 0, 1, 1, 8'h5A, "R10");
        step(2'b10, 1, 0, 0, 0, 8'h0D, "R4");
        step(2'b10, 1, 0, 1, 1, 8'h42, "R10");
        // Mode 11 acts as free (R11)
        step(2'b11, 1, 0, 0, 0, 8'hFF, "R4");
        step(2'b11, 1, 1, 1, 1, 8'h00, "R11");
        step(2'b11, 1, 0, 0, 0, 8'h0D, "R4");
        step(2'b11, 1, 1, 1, 1, 8'h00, "R11");
        // Mid-run reset (R1)
        step(2'b00, 1, 0, 0, 0, 8'h99, "R4");
        do_reset();

        // Constrained random phase
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] m;
            logic       c, l, p, t;
            logic [7:0] d;
            logic [7:0] picks [6];
            picks[0] = 8'hFE; picks[1] = 8'hFF; picks[2] = 8'h0C;
            picks[3] = 8'h0D; picks[4] = 8'h0F; picks[5] = 8'h05;
            m = 2'($urandom_range(0, 3));
            c = ($urandom_range(0, 15) != 0);
            l = ($urandom_range(0, 11) != 0);
            p = ($urandom_range(0, 3) != 0);
            t = ($urandom_range(0, 3) != 0);
            d = ($urandom_range(0, 1) == 0) ? picks[$urandom_range(0, 5)]
                                            : 8'($urandom);
            step(m, c, l, p, t, d, "");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule